// File: doc/BRIEF.md
# Accumulator Rotate and Flag Update Unit

This unit performs the single-bit accumulator rotates of an 8-bit processor datapath and produces the matching flag byte. The sequencer presents the accumulator, the current flag byte and a two-bit operation code, then raises a one-cycle valid strobe. On the next clock edge the unit registers the rotated accumulator and the updated flags, and it pulses `done` for that cycle.

Left rotates come in two forms. The through-carry form moves the old carry into bit 0. The circular form wraps the old bit 7 round into bit 0. In both forms the bit that leaves the byte becomes the new carry. Mirrored right rotates are built when `HAS_RIGHT` is set, which is the default. The accumulator forms touch only carry, half-carry, subtract and the two undocumented copy bits. Sign, zero and parity/overflow pass through unchanged from the input flag byte.

Flag byte layout, from bit 7 down to bit 0:

- bit 7: S (sign)
- bit 6: Z (zero)
- bit 5: X5 (undocumented copy bit)
- bit 4: H (half-carry)
- bit 3: X3 (undocumented copy bit)
- bit 2: P/V (parity/overflow)
- bit 1: N (subtract)
- bit 0: C (carry)

Top module: `accum_rotate_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `acc_out` and `flags_out` become 0x00 and `done` becomes 0. This holds even if `op_valid` is high in the same cycle.
- R2: For the left rotates (`op_sel[1]`=0), the new carry (`flags_out` bit 0) equals the old accumulator bit 7.
- R3: With `op_sel`=2'b00 (left through carry), `acc_out` equals `{acc_in[6:0], flags_in[0]}`.
- R4: With `op_sel`=2'b01 (left circular), `acc_out` equals `{acc_in[6:0], acc_in[7]}`. An input of 0x80 with carry 0 gives 0x01 and carry 1, whereas R3 gives 0x00 and carry 1 for the same input.
- R5: `flags_out` bit 5 and bit 3 are copies of bit 5 and bit 3 of the new accumulator.
- R6: `flags_out` bit 4 (H) and bit 1 (N) are 0 after every operation.
- R7: `flags_out` bit 7 (S), bit 6 (Z) and bit 2 (P/V) equal the same bits of `flags_in` sampled with the strobe.
- R8: The accumulator and flags update together on the clock edge that samples `op_valid`=1. `done` is high for exactly the cycle after each strobe, so back-to-back strobes give back-to-back `done` pulses.
- R9: In a cycle without a strobe, `acc_out` and `flags_out` hold their values whatever the data inputs do, and `done` is 0.
- R10: With `op_sel`=2'b10 (right through carry), the result is `{flags_in[0], acc_in[7:1]}`. With 2'b11 (right circular), the result is `{acc_in[0], acc_in[7:1]}`. For both, the new carry is the old bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle strobe that starts an operation |
| op_sel | input | 2 | Operation: 00 left through carry, 01 left circular, 10 right through carry, 11 right circular |
| acc_in | input | 8 | Accumulator operand |
| flags_in | input | 8 | Current flag byte |
| acc_out | output | 8 | Registered rotated accumulator |
| flags_out | output | 8 | Registered updated flag byte |
| done | output | 1 | High for one cycle after each strobe |

## Verification
Two functions can fall in the same cycle.

The first pair is reset and a strobe. The bench raises `rst` and `op_valid` together with a non-zero operand. It judges the result by a zero accumulator, a zero flag byte and no `done` pulse on the following cycle.

The second pair is the completion of one rotate and the start of the next. The bench holds `op_valid` high for two cycles and feeds the first result and its flags straight back as the second operand. It then checks that `done` stays high for both cycles and that the carry produced by the first rotate lands in bit 0 of the second result.

// File: rtl/arot_pkg.sv
package arot_pkg;

    localparam int ACC_W = 8;
    localparam int MSB   = ACC_W - 1;

    // flag byte bit positions
    localparam int F_C  = 0;
    localparam int F_N  = 1;
    localparam int F_PV = 2;
    localparam int F_X3 = 3;
    localparam int F_H  = 4;
    localparam int F_X5 = 5;
    localparam int F_Z  = 6;
    localparam int F_S  = 7;

    typedef logic [ACC_W-1:0] acc_t;

    typedef enum logic [1:0] {
        ROT_LEFT_THRU  = 2'b00,
        ROT_LEFT_CIRC  = 2'b01,
        ROT_RIGHT_THRU = 2'b10,
        ROT_RIGHT_CIRC = 2'b11
    } rot_op_e;

    typedef struct packed {
        acc_t value;
        logic carry;
    } shift_res_t;

    function automatic shift_res_t rotate_left(acc_t a, logic cin, logic circ);
        shift_res_t r;
        r.value = {a[MSB-1:0], (circ ? a[MSB] : cin)};
        r.carry = a[MSB];
        return r;
    endfunction

    function automatic shift_res_t rotate_right(acc_t a, logic cin, logic circ);
        shift_res_t r;
        r.value = {(circ ? a[0] : cin), a[MSB:1]};
        r.carry = a[0];
        return r;
    endfunction

endpackage

// File: rtl/arot_shifter.sv
module arot_shifter
    import arot_pkg::*;
#(
    parameter bit HAS_RIGHT = 1'b1
)(
    input  acc_t       acc,
    input  logic       carry_in,
    input  rot_op_e    op,
    output shift_res_t res
);

    logic circular;
    assign circular = (op == ROT_LEFT_CIRC) || (op == ROT_RIGHT_CIRC);

    generate
        if (HAS_RIGHT) begin : g_both_dirs
            logic go_right;
            assign go_right = (op == ROT_RIGHT_THRU) || (op == ROT_RIGHT_CIRC);
            always_comb begin
                if (go_right) res = rotate_right(acc, carry_in, circular);
                else          res = rotate_left(acc, carry_in, circular);
            end
        end else begin : g_left_only
            always_comb res = rotate_left(acc, carry_in, circular);
        end
    endgenerate

endmodule

// File: rtl/arot_flag_merge.sv
module arot_flag_merge
    import arot_pkg::*;
(
    input  acc_t result,
    input  logic carry_out,
    input  acc_t flags_prev,
    output acc_t flags_next
);

    always_comb begin
        flags_next       = '0;
        flags_next[F_S]  = flags_prev[F_S];
        flags_next[F_Z]  = flags_prev[F_Z];
        flags_next[F_PV] = flags_prev[F_PV];
        flags_next[F_X5] = result[F_X5];
        flags_next[F_X3] = result[F_X3];
        flags_next[F_H]  = 1'b0;
        flags_next[F_N]  = 1'b0;
        flags_next[F_C]  = carry_out;
    end

endmodule

// File: rtl/accum_rotate_unit.sv
module accum_rotate_unit
    import arot_pkg::*;
#(
    parameter bit HAS_RIGHT = 1'b1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [1:0]       op_sel,
    input  logic [ACC_W-1:0] acc_in,
    input  logic [ACC_W-1:0] flags_in,
    output logic [ACC_W-1:0] acc_out,
    output logic [ACC_W-1:0] flags_out,
    output logic             done
);

    shift_res_t shifted;
    acc_t       flags_new;
    rot_op_e    op;

    assign op = rot_op_e'(op_sel);

    arot_shifter #(.HAS_RIGHT(HAS_RIGHT)) u_shift (
        .acc      (acc_in),
        .carry_in (flags_in[F_C]),
        .op       (op),
        .res      (shifted)
    );

    arot_flag_merge u_flags (
        .result     (shifted.value),
        .carry_out  (shifted.carry),
        .flags_prev (flags_in),
        .flags_next (flags_new)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_out   <= '0;
            flags_out <= '0;
            done      <= 1'b0;
        end else begin
            done <= op_valid;
            if (op_valid) begin
                acc_out   <= shifted.value;
                flags_out <= flags_new;
            end
        end
    end

endmodule

// File: rtl/accum_rotate_unit_chk.sv
module accum_rotate_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       op_valid,
    input logic [1:0] op_sel,
    input logic [7:0] acc_in,
    input logic [7:0] flags_in,
    input logic [7:0] acc_out,
    input logic [7:0] flags_out,
    input logic       done
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (acc_out == 8'h00 && flags_out == 8'h00 && !done));

    // R2
    left_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_sel[1]) |=> flags_out[0] == $past(acc_in[7]));

    // R3
    left_thru_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 2'b00) |=>
            acc_out == {$past(acc_in[6:0]), $past(flags_in[0])});

    // R4
    left_circ_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 2'b01) |=>
            acc_out == {$past(acc_in[6:0]), $past(acc_in[7])});

    // R5
    copy_bits_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (flags_out[5] == acc_out[5] && flags_out[3] == acc_out[3]));

    // R6
    h_n_clear_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!flags_out[4] && !flags_out[1]));

    // R7
    keep_szp_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> (flags_out[7] == $past(flags_in[7]) &&
                      flags_out[6] == $past(flags_in[6]) &&
                      flags_out[2] == $past(flags_in[2])));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> done);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!done && $stable(acc_out) && $stable(flags_out)));

    // R10
    right_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel[1]) |=> flags_out[0] == $past(acc_in[0]));

endmodule

bind accum_rotate_unit accum_rotate_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_sel    (op_sel),
    .acc_in    (acc_in),
    .flags_in  (flags_in),
    .acc_out   (acc_out),
    .flags_out (flags_out),
    .done      (done)
);

// File: tb/accum_rotate_unit_test.sv
module accum_rotate_unit_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [1:0] op_sel = 2'b00;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] flags_in = 8'h00;
    logic [7:0] acc_out;
    logic [7:0] flags_out;
    logic       done;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    accum_rotate_unit uut (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .op_sel    (op_sel),
        .acc_in    (acc_in),
        .flags_in  (flags_in),
        .acc_out   (acc_out),
        .flags_out (flags_out),
        .done      (done)
    );

    // {op, acc, flags, expected acc, expected flags}
    localparam int NV = 11;
    localparam logic [33:0] VECS [NV] = '{
        {2'b00, 8'h80, 8'h00, 8'h00, 8'h01},  // R3 R2
        {2'b01, 8'h80, 8'h00, 8'h01, 8'h01},  // R4 R2
        {2'b00, 8'h55, 8'h01, 8'hAB, 8'h28},  // R3 R5
        {2'b01, 8'hC3, 8'hFF, 8'h87, 8'hC5},  // R4 R6 R7
        {2'b00, 8'h14, 8'hD6, 8'h28, 8'hEC},  // R3 R6 R7
        {2'b10, 8'h01, 8'h00, 8'h00, 8'h01},  // R10
        {2'b11, 8'h01, 8'h00, 8'h80, 8'h01},  // R10
        {2'b10, 8'hAA, 8'h01, 8'hD5, 8'h00},  // R10
        {2'b11, 8'h3D, 8'h44, 8'h9E, 8'h4D},  // R10 R7
        {2'b01, 8'h7F, 8'h00, 8'hFE, 8'h28},  // R4 R5
        {2'b00, 8'hFF, 8'h00, 8'hFE, 8'h29}   // R3 R2
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 acc", acc_out, 8'h00);
        check("R1 flags", flags_out, 8'h00);
        check("R1 done", {7'd0, done}, 8'h00);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_sel   = VECS[i][33:32];
            acc_in   = VECS[i][31:24];
            flags_in = VECS[i][23:16];
            op_valid = 1'b1;
            @(negedge clk);
            op_valid = 1'b0;
            check($sformatf("R8 done vec%0d", i), {7'd0, done}, 8'h01);
            check($sformatf("R3/R4/R10 acc vec%0d", i), acc_out, VECS[i][15:8]);
            check($sformatf("R2/R5/R6/R7 flags vec%0d", i), flags_out, VECS[i][7:0]);
        end

        // R9: no strobe, inputs change, outputs hold
        acc_in   = 8'h5A;
        flags_in = 8'hFF;
        op_sel   = 2'b01;
        repeat (2) @(negedge clk);
        check("R9 done", {7'd0, done}, 8'h00);
        check("R9 acc hold", acc_out, 8'hFE);
        check("R9 flags hold", flags_out, 8'h29);

        // R8: back-to-back strobes, chain result into next operand
        op_sel   = 2'b00;
        acc_in   = 8'h80;
        flags_in = 8'h00;
        op_valid = 1'b1;
        @(negedge clk);
        check("R8 done first", {7'd0, done}, 8'h01);
        check("R3 acc first", acc_out, 8'h00);
        check("R2 flags first", flags_out, 8'h01);
        acc_in   = acc_out;
        flags_in = flags_out;
        @(negedge clk);
        op_valid = 1'b0;
        check("R8 done second", {7'd0, done}, 8'h01);
        check("R3 acc chained", acc_out, 8'h01);
        check("R2 flags chained", flags_out, 8'h00);
        @(negedge clk);
        check("R8 done drops", {7'd0, done}, 8'h00);

        // R1: reset dominates a strobe in the same cycle
        op_sel   = 2'b01;
        acc_in   = 8'hFF;
        flags_in = 8'hFF;
        op_valid = 1'b1;
        rst      = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        check("R1 acc with strobe", acc_out, 8'h00);
        check("R1 flags with strobe", flags_out, 8'h00);
        check("R1 done with strobe", {7'd0, done}, 8'h00);
        rst = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule